// File: doc/BRIEF.md
# Indexed Register Access Bridge

This bridge lets a host with only a small register window reach a 28-bit command and data address space inside a controller core. The host writes the full target address into a control register. Each later access to a separate data register becomes one transaction on the core side at that stored address. A data-register write forwards its data to the core. A data-register read fetches a word from the core and returns it to the host. The stored address stays in place, so a stream of data-register accesses, such as a page moved word by word, needs only one control write in front of it.

The host side is a simple 32-bit memory-mapped slave. The host raises `h_req` with `h_write`, `h_addr` and `h_wdata` and holds them until it sees `h_ready` high for one cycle. The core side is a request/acknowledge master. `c_req` stays high, with address, direction and write data unchanged, until the core returns `c_ack`. While a forwarded transaction is in flight the host is stalled.

One controller, `idxb_fsm`, sequences every host access through three states:
- `ST_IDLE` waits for a host request.
- `ST_ISSUE` holds the core request until it is acknowledged.
- `ST_RESP` gives the host its one-cycle completion.

The transitions are:
- `T_REG`: `ST_IDLE` to `ST_RESP` when the request targets the control register or an unmapped offset.
- `T_FWD`: `ST_IDLE` to `ST_ISSUE` when the request targets the data register.
- `T_ACK`: `ST_ISSUE` to `ST_RESP` when the core acknowledges.
- `T_DONE`: `ST_RESP` back to `ST_IDLE`, unconditionally.

The state holds while `h_req` is low in `ST_IDLE`, and while `c_ack` is low in `ST_ISSUE`.

Top module: `idx_reg_bridge`

## Requirements
- R1: After reset, `h_ready` and `c_req` are low, and a control-register read returns 0.
- R2: A write to host offset 0x00 (control register) keeps bits 27:0 of `h_wdata` as the target address. A read of offset 0x00 returns that address with bits 31:28 zero.
- R3: A write to host offset 0x10 (data register) starts exactly one core transaction. In it `c_we`=1, `c_addr` is the stored address and `c_wdata` is the host data. These stay stable while `c_req` waits for `c_ack`.
- R4: A read of offset 0x10 starts one core transaction with `c_we`=0. It returns on `h_rdata` the `c_rdata` value present with `c_ack`.
- R5: A data-register access keeps `h_ready` low until the core acknowledges. `h_ready` rises in the cycle after the acknowledge cycle, so an access whose core answers after D extra cycles completes 2+D cycles after the request is taken. `h_ready` is a single-cycle pulse, and it is never high while `c_req` is high.
- R6: The stored address persists, so consecutive data-register accesses with no control write in between all use the same `c_addr`.
- R7: An access to any offset other than 0x00 or 0x10 (for example 0x04, 0x11, 0x14) completes, reads as zero, leaves the stored address unchanged and starts no core transaction.
- R8: `c_map` shows bits 27:26 of the stored address (access map select) and `c_bank` shows bits 25:24 (bank number).
- R9: `c_req` falls in the cycle after the acknowledge cycle, so each data access produces exactly one acknowledged core transaction.
- R10: A control-register or unmapped access completes one cycle after it is taken, with no core transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_req | input | 1 | Host access request, held until `h_ready` |
| h_write | input | 1 | Host access is a write |
| h_addr | input | 8 | Host byte offset in the window |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid with `h_ready` |
| h_ready | output | 1 | Host access complete (one-cycle pulse) |
| c_req | output | 1 | Core transaction request |
| c_we | output | 1 | Core transaction is a write |
| c_addr | output | 28 | Core target address (stored address) |
| c_wdata | output | 32 | Core write data |
| c_map | output | 2 | Access map field of the stored address |
| c_bank | output | 2 | Bank field of the stored address |
| c_ack | input | 1 | Core acknowledge |
| c_rdata | input | 32 | Core read data, valid with `c_ack` |

## Verification
The hardest case to reach from the ports is a host stalled across a long core wait. During that wait the forwarded request must stay frozen and exactly one transaction must be counted. The bench gets there with a core responder whose acknowledge latency is set per scenario: zero, three and seven cycles. It measures the host-side completion latency and logs every acknowledged transaction, which shows both the stall length and the single forward. Unmapped-offset accesses are placed between control and data accesses, and their lack of effect is shown through a control-register read-back and the unchanged transaction log.

// File: rtl/idxb_pkg.sv
package idxb_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_RESP  = 2'd2
    } idxb_state_e;

    // Decoded target of a host access
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_DATA = 2'd1,
        SEL_NONE = 2'd2
    } idxb_sel_e;

endpackage

// File: rtl/idxb_decode.sv
module idxb_decode
    import idxb_pkg::*;
#(
    parameter int HADDR_W  = 8,
    parameter int CTRL_OFF = 0,
    parameter int DATA_OFF = 16
) (
    input  logic [HADDR_W-1:0] h_addr,
    output idxb_sel_e          sel
);

    localparam logic [HADDR_W-1:0] CTRL_A = HADDR_W'(CTRL_OFF);
    localparam logic [HADDR_W-1:0] DATA_A = HADDR_W'(DATA_OFF);

    // Exact offset match; anything else is unmapped
    always_comb begin
        if (h_addr == CTRL_A)
            sel = SEL_CTRL;
        else if (h_addr == DATA_A)
            sel = SEL_DATA;
        else
            sel = SEL_NONE;
    end

endmodule

// File: rtl/idxb_addr_latch.sv
module idxb_addr_latch #(
    parameter int TADDR_W = 28,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [TADDR_W-1:0] load_val,
    output logic [TADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0]  readback
);

    localparam int PAD_W = DATA_W - TADDR_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_q <= '0;
        else if (load)
            addr_q <= load_val;
    end

    // Upper bits above the target width read back as zero
    generate
        if (PAD_W > 0) begin : g_pad
            assign readback = {{PAD_W{1'b0}}, addr_q};
        end else begin : g_nopad
            assign readback = addr_q[DATA_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/idxb_fsm.sv
module idxb_fsm
    import idxb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        h_req,
    input  idxb_sel_e   sel,
    input  logic        c_ack,
    output idxb_state_e state,
    output logic        take_reg,
    output logic        take_fwd,
    output logic        ack_seen,
    output logic        issuing,
    output logic        responding
);

    idxb_state_e state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Transitions: T_REG, T_FWD, T_ACK, T_DONE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (h_req) begin
                    if (sel == SEL_DATA)
                        state_nx = ST_ISSUE;   // T_FWD
                    else
                        state_nx = ST_RESP;    // T_REG
                end
            end
            ST_ISSUE: begin
                if (c_ack)
                    state_nx = ST_RESP;        // T_ACK
            end
            ST_RESP: state_nx = ST_IDLE;       // T_DONE
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        take_reg   = 1'b0;
        take_fwd   = 1'b0;
        ack_seen   = 1'b0;
        issuing    = 1'b0;
        responding = 1'b0;
        unique case (state)
            ST_IDLE: begin
                take_reg = h_req && (sel != SEL_DATA);
                take_fwd = h_req && (sel == SEL_DATA);
            end
            ST_ISSUE: begin
                issuing  = 1'b1;
                ack_seen = c_ack;
            end
            ST_RESP: responding = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/idx_reg_bridge.sv
module idx_reg_bridge
    import idxb_pkg::*;
#(
    parameter int HADDR_W  = 8,
    parameter int DATA_W   = 32,
    parameter int TADDR_W  = 28,
    parameter int CTRL_OFF = 0,
    parameter int DATA_OFF = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               h_req,
    input  logic               h_write,
    input  logic [HADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0]  h_wdata,
    output logic [DATA_W-1:0]  h_rdata,
    output logic               h_ready,
    output logic               c_req,
    output logic               c_we,
    output logic [TADDR_W-1:0] c_addr,
    output logic [DATA_W-1:0]  c_wdata,
    output logic [1:0]         c_map,
    output logic [1:0]         c_bank,
    input  logic               c_ack,
    input  logic [DATA_W-1:0]  c_rdata
);

    localparam int MAP_LSB  = TADDR_W - 2;
    localparam int BANK_LSB = TADDR_W - 4;

    idxb_sel_e   sel;
    idxb_state_e state;
    logic        take_reg, take_fwd, ack_seen, issuing, responding;
    logic [TADDR_W-1:0] addr_q;
    logic [DATA_W-1:0]  ctrl_rb;
    logic [DATA_W-1:0]  wdata_q;
    logic               we_q;
    logic [DATA_W-1:0]  rdata_q;

    idxb_decode #(
        .HADDR_W (HADDR_W),
        .CTRL_OFF(CTRL_OFF),
        .DATA_OFF(DATA_OFF)
    ) u_dec (
        .h_addr(h_addr),
        .sel   (sel)
    );

    idxb_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .h_req     (h_req),
        .sel       (sel),
        .c_ack     (c_ack),
        .state     (state),
        .take_reg  (take_reg),
        .take_fwd  (take_fwd),
        .ack_seen  (ack_seen),
        .issuing   (issuing),
        .responding(responding)
    );

    idxb_addr_latch #(
        .TADDR_W(TADDR_W),
        .DATA_W (DATA_W)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (take_reg && h_write && (sel == SEL_CTRL)),
        .load_val(h_wdata[TADDR_W-1:0]),
        .addr_q  (addr_q),
        .readback(ctrl_rb)
    );

    // Forwarded data and direction, captured when the data access is taken
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdata_q <= '0;
            we_q    <= 1'b0;
        end else if (take_fwd) begin
            wdata_q <= h_wdata;
            we_q    <= h_write;
        end
    end

    // Host read data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (take_reg) begin
            if (sel == SEL_CTRL && !h_write)
                rdata_q <= ctrl_rb;
            else
                rdata_q <= '0;
        end else if (ack_seen) begin
            rdata_q <= we_q ? '0 : c_rdata;
        end
    end

    assign h_ready = responding;
    assign h_rdata = rdata_q;
    assign c_req   = issuing;
    assign c_we    = we_q;
    assign c_addr  = addr_q;
    assign c_wdata = wdata_q;
    assign c_map   = addr_q[MAP_LSB +: 2];
    assign c_bank  = addr_q[BANK_LSB +: 2];

endmodule

// File: rtl/idxb_chk.sv
module idxb_chk #(
    parameter int HADDR_W  = 8,
    parameter int DATA_W   = 32,
    parameter int TADDR_W  = 28,
    parameter int DATA_OFF = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               h_req,
    input logic               h_write,
    input logic [HADDR_W-1:0] h_addr,
    input logic [DATA_W-1:0]  h_rdata,
    input logic               h_ready,
    input logic               c_req,
    input logic               c_we,
    input logic [TADDR_W-1:0] c_addr,
    input logic [DATA_W-1:0]  c_wdata,
    input logic               c_ack,
    input logic [DATA_W-1:0]  c_rdata
);

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_req && !c_ack) |=> (c_req && $stable(c_addr) && $stable(c_we) && $stable(c_wdata)));

    // R9
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_req && c_ack) |=> !c_req);

    // R5
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_ready |=> !h_ready);

    // R5
    no_ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_req |-> !h_ready);

    // R7
    fwd_from_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_req) |-> ($past(h_req) && $past(h_addr) == HADDR_W'(DATA_OFF)));

    // R4
    read_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_ready && h_req && !h_write && $past(c_req && c_ack)) |-> (h_rdata == $past(c_rdata)));

endmodule

bind idx_reg_bridge idxb_chk #(
    .HADDR_W (HADDR_W),
    .DATA_W  (DATA_W),
    .TADDR_W (TADDR_W),
    .DATA_OFF(DATA_OFF)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .h_req  (h_req),
    .h_write(h_write),
    .h_addr (h_addr),
    .h_rdata(h_rdata),
    .h_ready(h_ready),
    .c_req  (c_req),
    .c_we   (c_we),
    .c_addr (c_addr),
    .c_wdata(c_wdata),
    .c_ack  (c_ack),
    .c_rdata(c_rdata)
);

// File: tb/idx_reg_bridge_tb.sv
module idx_reg_bridge_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_req = 1'b0;
    logic        h_write = 1'b0;
    logic [7:0]  h_addr = '0;
    logic [31:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic        h_ready;
    logic        c_req;
    logic        c_we;
    logic [27:0] c_addr;
    logic [31:0] c_wdata;
    logic [1:0]  c_map;
    logic [1:0]  c_bank;
    logic        c_ack = 1'b0;
    logic [31:0] c_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Core responder state
    int          ack_delay = 0;
    int          wait_cnt = 0;
    int          txn_cnt = 0;
    logic [27:0] last_addr = '0;
    logic        last_we = 1'b0;
    logic [31:0] last_wdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idx_reg_bridge u_dut (
        .clk(clk), .rst_n(rst_n),
        .h_req(h_req), .h_write(h_write), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_ready(h_ready),
        .c_req(c_req), .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata),
        .c_map(c_map), .c_bank(c_bank), .c_ack(c_ack), .c_rdata(c_rdata)
    );

    function automatic logic [31:0] core_word(input logic [27:0] a);
        return {a, 4'h5} ^ 32'h3C3C_0F0F;
    endfunction

    // Core model: acknowledges after ack_delay extra cycles
    always @(negedge clk) begin
        if (!rst_n) begin
            c_ack = 1'b0;
            wait_cnt = 0;
        end else if (c_ack) begin
            c_ack = 1'b0;
            wait_cnt = 0;
        end else if (c_req) begin
            if (wait_cnt >= ack_delay) begin
                c_ack = 1'b1;
                c_rdata = core_word(c_addr);
                txn_cnt++;
                last_addr = c_addr;
                last_we = c_we;
                last_wdata = c_wdata;
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic host_xfer(input logic we, input logic [7:0] a, input logic [31:0] d,
                             output logic [31:0] rd, output int cyc);
        @(negedge clk);
        h_req = 1'b1; h_write = we; h_addr = a; h_wdata = d;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!h_ready && cyc < 100);
        rd = h_rdata;
        h_req = 1'b0; h_write = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] rd; int cyc;
        check("R1 h_ready", 32'(h_ready), 0);
        check("R1 c_req", 32'(c_req), 0);
        host_xfer(1'b0, 8'h00, '0, rd, cyc);
        check("R1 ctrl reset value", rd, 0);
    endtask

    task automatic t_ctrl();
        logic [31:0] rd; int cyc; int t0;
        t0 = txn_cnt;
        host_xfer(1'b1, 8'h00, 32'hFABC_DE12, rd, cyc);
        check("R10 ctrl write latency", cyc, 1);
        host_xfer(1'b0, 8'h00, '0, rd, cyc);
        check("R2 ctrl readback", rd, 32'h0ABC_DE12);
        check("R10 ctrl read latency", cyc, 1);
        check("R10 no core txn", txn_cnt, t0);
        check("R8 map", 32'(c_map), 2'b10);
        check("R8 bank", 32'(c_bank), 2'b10);
        host_xfer(1'b1, 8'h00, 32'h0512_3456, rd, cyc);
        check("R8 map second", 32'(c_map), 2'b01);
        check("R8 bank second", 32'(c_bank), 2'b01);
    endtask

    task automatic t_data_write(input int dly, input logic [31:0] d);
        logic [31:0] rd; int cyc; int t0;
        ack_delay = dly;
        t0 = txn_cnt;
        host_xfer(1'b1, 8'h10, d, rd, cyc);
        check("R9 one txn per write", txn_cnt, t0 + 1);
        check("R3 c_we", 32'(last_we), 1);
        check("R3 c_addr", 32'(last_addr), 32'h0512_3456);
        check("R3 c_wdata", last_wdata, d);
        check("R5 write latency", cyc, 2 + dly);
        check("R9 c_req dropped", 32'(c_req), 0);
    endtask

    task automatic t_data_read(input int dly);
        logic [31:0] rd; int cyc; int t0;
        ack_delay = dly;
        t0 = txn_cnt;
        host_xfer(1'b0, 8'h10, 32'hDEAD_BEEF, rd, cyc);
        check("R9 one txn per read", txn_cnt, t0 + 1);
        check("R4 c_we low", 32'(last_we), 0);
        check("R4 read data", rd, core_word(28'h512_3456));
        check("R5 read latency", cyc, 2 + dly);
    endtask

    task automatic t_stream();
        logic [31:0] rd; int cyc; int t0;
        ack_delay = 1;
        host_xfer(1'b1, 8'h00, 32'h0C00_0040, rd, cyc);
        t0 = txn_cnt;
        for (int i = 0; i < 4; i++) begin
            host_xfer(1'b1, 8'h10, 32'h1000_0000 + i, rd, cyc);
            check("R6 stream addr", 32'(last_addr), 32'h0C00_0040);
            check("R6 stream data", last_wdata, 32'h1000_0000 + i);
        end
        host_xfer(1'b0, 8'h10, '0, rd, cyc);
        check("R6 stream read addr", 32'(last_addr), 32'h0C00_0040);
        check("R6 stream read data", rd, core_word(28'hC00_0040));
        check("R6 txn count", txn_cnt, t0 + 5);
    endtask

    task automatic t_unmapped();
        logic [31:0] rd; int cyc; int t0;
        t0 = txn_cnt;
        host_xfer(1'b1, 8'h04, 32'h0FFF_FFFF, rd, cyc);
        check("R10 unmapped write latency", cyc, 1);
        host_xfer(1'b1, 8'h11, 32'h0123_4567, rd, cyc);
        host_xfer(1'b0, 8'h14, '0, rd, cyc);
        check("R7 unmapped read zero", rd, 0);
        host_xfer(1'b0, 8'hF0, '0, rd, cyc);
        check("R7 high unmapped read zero", rd, 0);
        host_xfer(1'b0, 8'h00, '0, rd, cyc);
        check("R7 ctrl unchanged", rd, 32'h0C00_0040);
        check("R7 no core txn", txn_cnt, t0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_data_write(0, 32'hA5A5_1234);
        t_data_write(3, 32'h0000_FFFF);
        t_data_read(0);
        t_data_read(7);
        t_stream();
        t_unmapped();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule